// File: doc/BRIEF.md
# Banked Memory Mapping Unit

This block sits between a CPU with a 16-bit logical address space and a 21-bit physical memory system. The logical space is cut into eight pages of 8 KB. Each page has its own register, and that register names one of 256 physical banks. The bank number forms the upper bits of the physical address. The low 13 logical address bits pass through unchanged. The translation is combinational, so a memory access needs no extra cycle.

The bank number also sets the kind of access. The lower half of the bank space is read-only ROM. Four banks hold work RAM. A single bank is the I/O page, which can be read but not written as memory. Every other bank is unmapped. The block turns the CPU's read and write requests into one strobe for the matching target. On an unmapped read it also drives a fixed fill byte, which is set by a parameter.

Page registers are loaded through a small write port that takes a page index and a bank value. A loaded value reroutes that page from the next clock edge.

Top module: `mmu_bank_xlate`

## Requirements
- R1: `phys_addr` equals the selected page's bank number in bits 20:13, followed by `cpu_addr[12:0]` in bits 12:0.
- R2: The page register used for translation is chosen by `cpu_addr[15:13]`, which is a page index from 0 to 7.
- R3: After synchronous reset, all eight page registers hold bank 0x00.
- R4: A page write (`pg_we`, `pg_idx`, `pg_bank`) changes translation from the next rising clock edge. Translation in the cycle of the write still uses the old bank.
- R5: Banks 0x00 to 0x7F are ROM. A read of one of these banks raises `rom_rd`. A write to one raises no strobe at all.
- R6: Banks 0xF8 to 0xFB are work RAM. A read raises `ram_rd` and a write raises `ram_wr`.
- R7: Bank 0xFF is the I/O page. A read raises `io_sel`. A write raises no strobe.
- R8: Every other bank is unmapped, and a read or a write of it raises `unmapped`. `fill_data` is 0xFF (the default of the UNMAP_BYTE parameter) during an unmapped read, and 0x00 at all other times.
- R9: During a read, exactly one of `rom_rd`, `ram_rd`, `io_sel`, `unmapped` is high. When neither `cpu_rd` nor `cpu_wr` is high, all five strobes are low.
- R10: When `cpu_rd` and `cpu_wr` are high together, the access is treated as a read only, and `ram_wr` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Logical CPU address |
| cpu_rd | input | 1 | Read request |
| cpu_wr | input | 1 | Write request |
| pg_we | input | 1 | Page register write enable |
| pg_idx | input | 3 | Page register to load |
| pg_bank | input | 8 | Bank value to load |
| phys_addr | output | 21 | Translated physical address |
| rom_rd | output | 1 | ROM read strobe |
| ram_rd | output | 1 | Work RAM read strobe |
| ram_wr | output | 1 | Work RAM write strobe |
| io_sel | output | 1 | I/O page read select |
| unmapped | output | 1 | Access hit an unmapped bank |
| fill_data | output | 8 | Fill byte for unmapped reads |

## Verification
The hardest case to reach is a page write that targets the same page the CPU is addressing in that same cycle. In that case the old bank must still show, and the new bank must take over at the next edge. Purely random traffic seldom makes the two indices match. The bench therefore includes a directed step that writes page 5 while reading page 5, and then checks again after the edge. Random bank values rarely land on the exact class boundaries, so a directed sweep loads banks 0x7F, 0x80, 0xF7, 0xF8, 0xFB, 0xFC, 0xFE and 0xFF, each under both a read and a write.

// File: rtl/mmu_bank_pkg.sv
package mmu_bank_pkg;

    typedef enum logic [1:0] {
        CLS_ROM  = 2'd0,
        CLS_RAM  = 2'd1,
        CLS_IO   = 2'd2,
        CLS_NONE = 2'd3
    } bank_cls_e;

    typedef struct packed {
        logic rom_rd;
        logic ram_rd;
        logic ram_wr;
        logic io_sel;
        logic unmapped;
    } strobe_t;

    // The I/O bank is tested first so that it wins if it overlaps a range.
    function automatic bank_cls_e classify_bank(
        input int unsigned bank,
        input int unsigned rom_last,
        input int unsigned ram_first,
        input int unsigned ram_count,
        input int unsigned io_bank
    );
        if (bank == io_bank)
            return CLS_IO;
        else if (bank <= rom_last)
            return CLS_ROM;
        else if (bank >= ram_first && bank < ram_first + ram_count)
            return CLS_RAM;
        else
            return CLS_NONE;
    endfunction

endpackage

// File: rtl/mmu_page_file.sv
module mmu_page_file #(
    parameter int NPAGES = 8,
    parameter int BANK_W = 8,
    localparam int IDX_W = $clog2(NPAGES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BANK_W-1:0] rd_bank
);

    logic [BANK_W-1:0] page_q [NPAGES];

    for (genvar g = 0; g < NPAGES; g++) begin : g_page
        always_ff @(posedge clk) begin
            if (rst)
                page_q[g] <= '0;
            else if (we && wr_idx == IDX_W'(g))
                page_q[g] <= wr_bank;
        end
    end

    assign rd_bank = page_q[rd_idx];

endmodule

// File: rtl/mmu_bank_class.sv
module mmu_bank_class
    import mmu_bank_pkg::*;
#(
    parameter int BANK_W    = 8,
    parameter int ROM_LAST  = 8'h7F,
    parameter int RAM_FIRST = 8'hF8,
    parameter int RAM_COUNT = 4,
    parameter int IO_BANK   = 8'hFF
) (
    input  logic [BANK_W-1:0] bank,
    output bank_cls_e         cls
);

    always_comb begin
        cls = classify_bank(int'(unsigned'(bank)), ROM_LAST, RAM_FIRST,
                            RAM_COUNT, IO_BANK);
    end

endmodule

// File: rtl/mmu_strobe_gen.sv
module mmu_strobe_gen
    import mmu_bank_pkg::*;
(
    input  bank_cls_e cls,
    input  logic      rd,
    input  logic      wr,
    output strobe_t   stb
);

    logic wr_only;
    assign wr_only = wr & ~rd;

    always_comb begin
        stb = '0;
        unique case (cls)
            CLS_ROM:  stb.rom_rd   = rd;
            CLS_RAM:  begin
                stb.ram_rd = rd;
                stb.ram_wr = wr_only;
            end
            CLS_IO:   stb.io_sel   = rd;
            CLS_NONE: stb.unmapped = rd | wr_only;
            default:  stb = '0;
        endcase
    end

endmodule

// File: rtl/mmu_bank_xlate.sv
module mmu_bank_xlate
    import mmu_bank_pkg::*;
#(
    parameter int LOG_AW     = 16,
    parameter int PAGE_BITS  = 3,
    parameter int BANK_W     = 8,
    parameter int ROM_LAST   = 8'h7F,
    parameter int RAM_FIRST  = 8'hF8,
    parameter int RAM_COUNT  = 4,
    parameter int IO_BANK    = 8'hFF,
    parameter logic [7:0] UNMAP_BYTE = 8'hFF,
    localparam int OFF_W  = LOG_AW - PAGE_BITS,
    localparam int PHYS_W = BANK_W + OFF_W,
    localparam int NPAGES = 1 << PAGE_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [LOG_AW-1:0]    cpu_addr,
    input  logic                 cpu_rd,
    input  logic                 cpu_wr,
    input  logic                 pg_we,
    input  logic [PAGE_BITS-1:0] pg_idx,
    input  logic [BANK_W-1:0]    pg_bank,
    output logic [PHYS_W-1:0]    phys_addr,
    output logic                 rom_rd,
    output logic                 ram_rd,
    output logic                 ram_wr,
    output logic                 io_sel,
    output logic                 unmapped,
    output logic [7:0]           fill_data
);

    logic [PAGE_BITS-1:0] page_sel;
    logic [BANK_W-1:0]    cur_bank;
    bank_cls_e            cur_cls;
    strobe_t              stb;

    assign page_sel = cpu_addr[LOG_AW-1:OFF_W];

    mmu_page_file #(
        .NPAGES (NPAGES),
        .BANK_W (BANK_W)
    ) u_pages (
        .clk     (clk),
        .rst     (rst),
        .we      (pg_we),
        .wr_idx  (pg_idx),
        .wr_bank (pg_bank),
        .rd_idx  (page_sel),
        .rd_bank (cur_bank)
    );

    mmu_bank_class #(
        .BANK_W    (BANK_W),
        .ROM_LAST  (ROM_LAST),
        .RAM_FIRST (RAM_FIRST),
        .RAM_COUNT (RAM_COUNT),
        .IO_BANK   (IO_BANK)
    ) u_class (
        .bank (cur_bank),
        .cls  (cur_cls)
    );

    mmu_strobe_gen u_stb (
        .cls (cur_cls),
        .rd  (cpu_rd),
        .wr  (cpu_wr),
        .stb (stb)
    );

    assign phys_addr = {cur_bank, cpu_addr[OFF_W-1:0]};
    assign rom_rd    = stb.rom_rd;
    assign ram_rd    = stb.ram_rd;
    assign ram_wr    = stb.ram_wr;
    assign io_sel    = stb.io_sel;
    assign unmapped  = stb.unmapped;
    assign fill_data = (stb.unmapped && cpu_rd) ? UNMAP_BYTE : 8'h00;

endmodule

// File: rtl/mmu_bank_xlate_chk.sv
module mmu_bank_xlate_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] cpu_addr,
    input logic        cpu_rd,
    input logic        cpu_wr,
    input logic        pg_we,
    input logic [2:0]  pg_idx,
    input logic [7:0]  pg_bank,
    input logic [20:0] phys_addr,
    input logic        rom_rd,
    input logic        ram_rd,
    input logic        ram_wr,
    input logic        io_sel,
    input logic        unmapped
);

    logic [7:0] bank_out;
    assign bank_out = phys_addr[20:13];

    // R3: the first cycle after reset shows bank 0 on every page
    p_reset_zero_r3: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> bank_out == 8'h00);

    // R4: a page load becomes visible at the next edge
    p_page_load_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(pg_we) && cpu_addr[15:13] == $past(pg_idx))
        |-> bank_out == $past(pg_bank));

    // R4: with no load, the same address translates the same way
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(pg_we) && cpu_addr == $past(cpu_addr))
        |-> $stable(phys_addr));

    // R9: a read picks exactly one target
    p_read_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        cpu_rd |-> $countones({rom_rd, ram_rd, io_sel, unmapped}) == 1);

    // R9: no request, no strobe
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!cpu_rd && !cpu_wr) |-> !(rom_rd | ram_rd | ram_wr | io_sel | unmapped));

    // R5: writes to ROM banks are dropped
    p_rom_wr_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && !cpu_rd && bank_out <= 8'h7F)
        |-> !(rom_rd | ram_rd | ram_wr | io_sel | unmapped));

    // R6: a RAM write strobe only occurs inside the RAM window
    p_ram_wr_window_r6: assert property (@(posedge clk) disable iff (rst)
        ram_wr |-> (bank_out >= 8'hF8 && bank_out <= 8'hFB && cpu_wr));

    // R7: the I/O page is never selected by a pure write
    p_io_no_wr_r7: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && !cpu_rd) |-> !io_sel);

    // R10: a combined request never produces a write strobe
    p_rd_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && cpu_wr) |-> !ram_wr);

endmodule

bind mmu_bank_xlate mmu_bank_xlate_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_addr  (cpu_addr),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .pg_we     (pg_we),
    .pg_idx    (pg_idx),
    .pg_bank   (pg_bank),
    .phys_addr (phys_addr),
    .rom_rd    (rom_rd),
    .ram_rd    (ram_rd),
    .ram_wr    (ram_wr),
    .io_sel    (io_sel),
    .unmapped  (unmapped)
);

// File: tb/mmu_bank_xlate_tb.sv
module mmu_bank_xlate_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic        pg_we = 1'b0;
    logic [2:0]  pg_idx = '0;
    logic [7:0]  pg_bank = '0;
    logic [20:0] phys_addr;
    logic        rom_rd, ram_rd, ram_wr, io_sel, unmapped;
    logic [7:0]  fill_data;

    int tests = 0;
    int fails = 0;
    logic [7:0] model_pg [8];

    always #2 clk = ~clk;

    mmu_bank_xlate u_dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .pg_we(pg_we), .pg_idx(pg_idx), .pg_bank(pg_bank),
        .phys_addr(phys_addr), .rom_rd(rom_rd), .ram_rd(ram_rd),
        .ram_wr(ram_wr), .io_sel(io_sel), .unmapped(unmapped),
        .fill_data(fill_data)
    );

    // {rom_rd, ram_rd, ram_wr, io_sel, unmapped} from the requirements
    function automatic logic [4:0] exp_stb(input logic [7:0] b, input logic rd, input logic wr);
        logic w;
        w = wr & ~rd;                                   // R10
        if (b == 8'hFF)                     return {3'b000, rd, 1'b0};        // R7
        if (b <= 8'h7F)                     return {rd, 4'b0000};             // R5
        if (b >= 8'hF8 && b <= 8'hFB)       return {1'b0, rd, w, 2'b00};      // R6
        return {4'b0000, rd | w};                                             // R8
    endfunction

    function automatic string req_of(input logic [7:0] b);
        if (b == 8'hFF) return "R7";
        if (b <= 8'h7F) return "R5";
        if (b >= 8'hF8 && b <= 8'hFB) return "R6";
        return "R8";
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Check all outputs for the present inputs against the model
    task automatic check_all(input string tag);
        logic [7:0] b;
        logic [4:0] es;
        b = model_pg[cpu_addr[15:13]];                                        // R2
        es = exp_stb(b, cpu_rd, cpu_wr);
        check({tag, " R1"}, 64'(phys_addr), 64'({b, cpu_addr[12:0]}));
        check({tag, " ", req_of(b)}, 64'({rom_rd, ram_rd, ram_wr, io_sel, unmapped}), 64'(es));
        check({tag, " R8 fill"}, 64'(fill_data), 64'((es[0] && cpu_rd) ? 8'hFF : 8'h00));
        if (cpu_rd)
            check({tag, " R9"}, 64'($countones({rom_rd, ram_rd, io_sel, unmapped})), 64'd1);
    endtask

    task automatic load_page(input logic [2:0] i, input logic [7:0] b);
        @(negedge clk);
        pg_we = 1'b1; pg_idx = i; pg_bank = b;
        @(posedge clk);
        model_pg[i] = b;
        @(negedge clk);
        pg_we = 1'b0;
    endtask

    task automatic access(input logic [15:0] a, input logic rd, input logic wr, input string tag);
        @(negedge clk);
        cpu_addr = a; cpu_rd = rd; cpu_wr = wr;
        #1;
        check_all(tag);
    endtask

    initial begin
        #150000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) model_pg[i] = 8'h00;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R3: every page reads bank 0 after reset
        for (int p = 0; p < 8; p++)
            access({3'(p), 13'h0ABC}, 1'b1, 1'b0, "R3 reset");

        // R9: idle gives no strobes
        access(16'h1234, 1'b0, 1'b0, "R9 idle");

        // R4: a load and a read of the same page in one cycle
        @(negedge clk);
        cpu_addr = 16'hA123; cpu_rd = 1'b1; cpu_wr = 1'b0;
        pg_we = 1'b1; pg_idx = 3'd5; pg_bank = 8'hF9;
        #1;
        check("R4 same-cycle old bank", 64'(phys_addr[20:13]), 64'h00);
        @(posedge clk);
        model_pg[5] = 8'hF9;
        @(negedge clk);
        pg_we = 1'b0;
        #1;
        check("R4 next-edge new bank", 64'(phys_addr[20:13]), 64'hF9);
        check_all("R4 after load");

        // Class boundaries, each read and written
        begin
            logic [7:0] edges [8];
            edges = '{8'h7F, 8'h80, 8'hF7, 8'hF8, 8'hFB, 8'hFC, 8'hFE, 8'hFF};
            for (int k = 0; k < 8; k++) begin
                load_page(3'd2, edges[k]);
                access(16'h4000 | 16'(k * 7), 1'b1, 1'b0, "edge rd");
                access(16'h5FFF, 1'b0, 1'b1, "edge wr");
                access(16'h4001, 1'b1, 1'b1, "R10 rd+wr");
            end
        end

        // Random traffic with random page loads in flight
        for (int n = 0; n < 600; n++) begin
            logic [1:0] op;
            @(negedge clk);
            pg_we   = ($urandom % 4) == 0;
            pg_idx  = 3'($urandom);
            pg_bank = ($urandom % 2) ? 8'hF8 | 8'($urandom % 8) : 8'($urandom);
            cpu_addr = 16'($urandom);
            op = 2'($urandom);
            cpu_rd = op[0]; cpu_wr = op[1];
            #1;
            check_all("rand");
            @(posedge clk);
            if (pg_we) model_pg[pg_idx] = pg_bank;
        end

        @(negedge clk);
        pg_we = 1'b0; cpu_rd = 1'b0; cpu_wr = 1'b0;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule